// File: doc/BRIEF.md
# Framed Multi-Phase Serial Transmitter

This block turns parallel words into framed serial data on one output line. Timing comes from an external bit clock and an external frame-sync input. Both are oversampled and synchronised in the system clock domain. A frame holds one or two phases. Each phase has its own element count and its own element width.

On an active frame-sync edge the block waits a set number of bit clocks. It then shifts each element out MSB first. The data line is driven only while element bits are on it, and an output-enable flag shows when that is.

Words arrive through a ready/valid port, one word per element, and pass through a single holding register. When an element must start and no word is available, the previous word is sent again and an underflow pulse is raised.

Top module: `frame_ser_tx`

## Requirements
- R1: After reset, `dx_oe` and `dx` are 0, `in_ready` is 1 and `underflow` is 0.
- R2: The active level of frame sync is 1 when `cfg_fs_pol`=0 and 0 when `cfg_fs_pol`=1. A change from inactive to active, seen on a sampling edge, starts a frame. The first bit is driven on the (1+delay)-th driving edge after that sampling edge, where delay is `cfg_dly` (code 3 behaves as 2).
- R3: With `cfg_clk_pol`=0, data is driven on rising bit-clock edges and frame sync is sampled on falling edges. With `cfg_clk_pol`=1 the two edges are swapped. `dx` and `dx_oe` never change except on a driving edge.
- R4: Element width codes are 000=8, 001=12, 010=16, 011=20, 100=24, and any other code gives 32 bits. Each element sends the low-order width bits of its word, MSB first, one bit per driving edge.
- R5: With `cfg_dual`=0 a frame is `cfg_cnt1`+1 elements of width `cfg_wd1`. `cfg_cnt2` and `cfg_wd2` have no effect.
- R6: With `cfg_dual`=1, `cfg_cnt1`+1 elements of width `cfg_wd1` are followed, with no gap, by `cfg_cnt2`+1 elements of width `cfg_wd2`. A count of 7Fh gives 128 elements.
- R7: `dx_oe` is 1 for exactly the bit clocks that carry element bits. While `dx_oe` is 0, `dx` is 0.
- R8: `in_ready` is 1 exactly when the holding register is empty. Each element start takes one word, so a frame consumes one supplied word per element.
- R9: If no word is held or offered when an element starts, `underflow` pulses for one clock cycle and the last word sent is sent again.
- R10: A word offered in the same clock cycle as an element start, with the holding register empty, is sent directly in that element and raises no underflow.
- R11: A new frame-sync edge that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fs_in | input | 1 | External transmit frame sync |
| cfg_dual | input | 1 | 0: single-phase frame, 1: dual-phase frame |
| cfg_cnt1 | input | 7 | Phase-1 element count minus one |
| cfg_wd1 | input | 3 | Phase-1 width code |
| cfg_cnt2 | input | 7 | Phase-2 element count minus one |
| cfg_wd2 | input | 3 | Phase-2 width code |
| cfg_dly | input | 2 | Bit clocks between frame sync and the first bit |
| cfg_clk_pol | input | 1 | Swaps the driving and sampling bit-clock edges |
| cfg_fs_pol | input | 1 | 1: frame sync is active low |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Holding register empty |
| in_data | input | 32 | Word to serialise |
| dx | output | 1 | Serial data |
| dx_oe | output | 1 | Data line driven |
| underflow | output | 1 | One-cycle pulse on a repeated word |

## Verification
An element start and the acceptance of a new word can fall on the same system clock cycle. In that cycle the buffer has to choose between the held word, the word being offered, and a repeat of the last word.

The bench provokes this coincidence by holding the supply back. It raises `in_valid` exactly two clock cycles after the bit-clock edge that begins the first element, which is the cycle in which the synchronised edge loads the shifter. The result is judged on the serial bits, on the absence of an underflow pulse, and on the number of words consumed.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_SHIFT = 2'd2
  } seq_state_e;

  // bits per element for a width code
  function automatic int unsigned elem_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 8;
      3'b001:  return 12;
      3'b010:  return 16;
      3'b011:  return 20;
      3'b100:  return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/ftx_sync_edge.sv
module ftx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fs_in,
  input  logic clk_pol,
  output logic drive_tick,
  output logic samp_tick,
  output logic fs_sync
);

  logic [SYNC_STAGES-1:0] bclk_sr_q, bclk_sr_n;
  logic [SYNC_STAGES-1:0] fs_sr_q, fs_sr_n;
  logic                   bclk_prev_q, bclk_prev_n;
  logic                   bclk_s, rise, fall;

  assign bclk_s = bclk_sr_q[SYNC_STAGES-1];
  assign fs_sync = fs_sr_q[SYNC_STAGES-1];

  always_comb begin
    bclk_sr_n   = {bclk_sr_q[SYNC_STAGES-2:0], bclk_in};
    fs_sr_n     = {fs_sr_q[SYNC_STAGES-2:0], fs_in};
    bclk_prev_n = bclk_s;
    rise        = bclk_s & ~bclk_prev_q;
    fall        = ~bclk_s & bclk_prev_q;
    drive_tick  = clk_pol ? fall : rise;
    samp_tick   = clk_pol ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sr_q   <= '0;
      fs_sr_q     <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      bclk_sr_q   <= bclk_sr_n;
      fs_sr_q     <= fs_sr_n;
      bclk_prev_q <= bclk_prev_n;
    end
  end

endmodule

// File: rtl/ftx_frame_seq.sv
module ftx_frame_seq
  import ftx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7,
  localparam int BCNT_W = $clog2(DATA_W),
  localparam int LEN_W  = BCNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_tick,
  input  logic              samp_tick,
  input  logic              fs_act,
  input  logic              cfg_dual,
  input  logic [CNT_W-1:0]  cfg_cnt1,
  input  logic [2:0]        cfg_wd1,
  input  logic [CNT_W-1:0]  cfg_cnt2,
  input  logic [2:0]        cfg_wd2,
  input  logic [1:0]        cfg_dly,
  output logic              load_evt,
  output logic              shift_evt,
  output logic              stop_evt,
  output logic [LEN_W-1:0]  load_len
);

  seq_state_e        st_q, st_n;
  logic [1:0]        dly_q, dly_n;
  logic              phase_q, phase_n;
  logic [CNT_W-1:0]  elem_q, elem_n;
  logic [BCNT_W-1:0] bit_q, bit_n;
  logic              fs_prev_q, fs_prev_n;

  logic [LEN_W-1:0]  len1, len2, cur_len;
  logic [CNT_W-1:0]  cur_cnt;
  logic              frame_start;

  assign len1    = LEN_W'(elem_bits(cfg_wd1));
  assign len2    = LEN_W'(elem_bits(cfg_wd2));
  assign cur_len = phase_q ? len2 : len1;
  assign cur_cnt = phase_q ? cfg_cnt2 : cfg_cnt1;
  assign frame_start = samp_tick & fs_act & ~fs_prev_q;

  always_comb begin
    st_n      = st_q;
    dly_n     = dly_q;
    phase_n   = phase_q;
    elem_n    = elem_q;
    bit_n     = bit_q;
    fs_prev_n = samp_tick ? fs_act : fs_prev_q;
    load_evt  = 1'b0;
    shift_evt = 1'b0;
    stop_evt  = 1'b0;
    load_len  = len1;
    case (st_q)
      SEQ_IDLE: begin
        if (frame_start) begin
          st_n  = SEQ_WAIT;
          dly_n = (cfg_dly == 2'd3) ? 2'd2 : cfg_dly;
        end
      end
      SEQ_WAIT: begin
        if (drive_tick) begin
          if (dly_q == 2'd0) begin
            load_evt = 1'b1;
            load_len = len1;
            phase_n  = 1'b0;
            elem_n   = '0;
            bit_n    = BCNT_W'(len1 - LEN_W'(1));
            st_n     = SEQ_SHIFT;
          end else begin
            dly_n = dly_q - 2'd1;
          end
        end
      end
      SEQ_SHIFT: begin
        if (drive_tick) begin
          if (bit_q != '0) begin
            shift_evt = 1'b1;
            bit_n     = bit_q - BCNT_W'(1);
          end else if (elem_q != cur_cnt) begin
            load_evt = 1'b1;
            load_len = cur_len;
            elem_n   = elem_q + CNT_W'(1);
            bit_n    = BCNT_W'(cur_len - LEN_W'(1));
          end else if (!phase_q && cfg_dual) begin
            load_evt = 1'b1;
            load_len = len2;
            phase_n  = 1'b1;
            elem_n   = '0;
            bit_n    = BCNT_W'(len2 - LEN_W'(1));
          end else begin
            stop_evt = 1'b1;
            st_n     = SEQ_IDLE;
          end
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      dly_q     <= '0;
      phase_q   <= 1'b0;
      elem_q    <= '0;
      bit_q     <= '0;
      fs_prev_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      dly_q     <= dly_n;
      phase_q   <= phase_n;
      elem_q    <= elem_n;
      bit_q     <= bit_n;
      fs_prev_q <= fs_prev_n;
    end
  end

endmodule

// File: rtl/ftx_word_buf.sv
module ftx_word_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              load_evt,
  output logic [DATA_W-1:0] word_out,
  output logic              underflow
);

  logic [DATA_W-1:0] hold_q, hold_n;
  logic [DATA_W-1:0] last_q, last_n;
  logic              hvld_q, hvld_n;
  logic              uf_q, uf_n;
  logic              take;
  logic              buf_en;

  assign in_ready  = ~hvld_q;
  assign take      = in_valid & ~hvld_q;
  assign underflow = uf_q;

  always_comb begin
    if (hvld_q)        word_out = hold_q;
    else if (in_valid) word_out = in_data;
    else               word_out = last_q;
  end

  always_comb begin
    hold_n = hold_q;
    last_n = last_q;
    hvld_n = hvld_q;
    uf_n   = 1'b0;
    if (load_evt) begin
      last_n = word_out;
      hvld_n = 1'b0;
      uf_n   = ~hvld_q & ~in_valid;
    end else if (take) begin
      hold_n = in_data;
      hvld_n = 1'b1;
    end
  end

  assign buf_en = load_evt | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      last_q <= '0;
      hvld_q <= 1'b0;
    end else if (buf_en) begin
      hold_q <= hold_n;
      last_q <= last_n;
      hvld_q <= hvld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= uf_n;
  end

endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic              stop_evt,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [DATA_W-1:0] word,
  output logic              dx,
  output logic              dx_oe
);

  logic [DATA_W-1:0] sh_q, sh_n, aligned;
  logic              dx_q, dx_n, oe_q, oe_n;
  logic              sh_en;

  assign aligned = word << (LEN_W'(DATA_W) - load_len);
  assign sh_en   = load_evt | shift_evt | stop_evt;
  assign dx      = dx_q;
  assign dx_oe   = oe_q;

  always_comb begin
    sh_n = sh_q;
    dx_n = dx_q;
    oe_n = oe_q;
    if (load_evt) begin
      dx_n = aligned[DATA_W-1];
      sh_n = aligned << 1;
      oe_n = 1'b1;
    end else if (shift_evt) begin
      dx_n = sh_q[DATA_W-1];
      sh_n = sh_q << 1;
    end else if (stop_evt) begin
      dx_n = 1'b0;
      sh_n = '0;
      oe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      dx_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (sh_en) begin
      sh_q <= sh_n;
      dx_q <= dx_n;
      oe_q <= oe_n;
    end
  end

endmodule

// File: rtl/frame_ser_tx.sv
module frame_ser_tx #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fs_in,
  input  logic              cfg_dual,
  input  logic [CNT_W-1:0]  cfg_cnt1,
  input  logic [2:0]        cfg_wd1,
  input  logic [CNT_W-1:0]  cfg_cnt2,
  input  logic [2:0]        cfg_wd2,
  input  logic [1:0]        cfg_dly,
  input  logic              cfg_clk_pol,
  input  logic              cfg_fs_pol,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              dx,
  output logic              dx_oe,
  output logic              underflow
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic              drive_tick, samp_tick, fs_sync, fs_act;
  logic              load_evt, shift_evt, stop_evt;
  logic [LEN_W-1:0]  load_len;
  logic [DATA_W-1:0] word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign fs_act = fs_sync ^ cfg_fs_pol;

  ftx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bclk_in    (bclk),
    .fs_in      (fs_in),
    .clk_pol    (cfg_clk_pol),
    .drive_tick (drive_tick),
    .samp_tick  (samp_tick),
    .fs_sync    (fs_sync)
  );

  ftx_frame_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .drive_tick (drive_tick),
    .samp_tick  (samp_tick),
    .fs_act     (fs_act),
    .cfg_dual   (cfg_dual),
    .cfg_cnt1   (cfg_cnt1),
    .cfg_wd1    (cfg_wd1),
    .cfg_cnt2   (cfg_cnt2),
    .cfg_wd2    (cfg_wd2),
    .cfg_dly    (cfg_dly),
    .load_evt   (load_evt),
    .shift_evt  (shift_evt),
    .stop_evt   (stop_evt),
    .load_len   (load_len)
  );

  ftx_word_buf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .load_evt  (load_evt),
    .word_out  (word),
    .underflow (underflow)
  );

  ftx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_evt  (load_evt),
    .shift_evt (shift_evt),
    .stop_evt  (stop_evt),
    .load_len  (load_len),
    .word      (word),
    .dx        (dx),
    .dx_oe     (dx_oe)
  );

endmodule

// File: rtl/frame_ser_tx_chk.sv
module frame_ser_tx_chk (
  input logic clk,
  input logic rst_n_s,
  input logic dx,
  input logic dx_oe,
  input logic in_valid,
  input logic in_ready,
  input logic underflow,
  input logic drive_tick,
  input logic load_evt
);

  // R3
  dx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !drive_tick |=> ($stable(dx) && $stable(dx_oe)));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dx_oe |-> !dx);

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(dx_oe) |-> $past(load_evt));

  // R8
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_ready && !load_evt) |=> !in_ready);

  // R9
  uf_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    underflow |-> ($past(load_evt) && dx_oe));

  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load_evt && in_valid && in_ready) |=> !underflow);

endmodule

bind frame_ser_tx frame_ser_tx_chk u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .dx         (dx),
  .dx_oe      (dx_oe),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .underflow  (underflow),
  .drive_tick (drive_tick),
  .load_evt   (load_evt)
);

// File: tb/frame_ser_tx_tb.sv
`timescale 1ns/1ps
module frame_ser_tx_tb;

  localparam int HB = 6;  // system clocks per bit-clock half period

  typedef struct packed {
    logic        dual;
    logic [6:0]  c1;
    logic [2:0]  w1;
    logic [6:0]  c2;
    logic [2:0]  w2;
    logic [1:0]  dly;
    logic        clkp;
    logic        fsp;
    logic [7:0]  nw;
    logic        late;
    logic        refs;
    logic [15:0] exp_bits;
    logic [7:0]  exp_uf;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0,   3'b000, 7'd0, 3'b000, 2'd1, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 16'd8,    8'd0},
    '{1'b0, 7'd3,   3'b010, 7'd5, 3'b101, 2'd0, 1'b0, 1'b0, 8'd4,   1'b0, 1'b0, 16'd64,   8'd0},
    '{1'b1, 7'd1,   3'b000, 7'd2, 3'b100, 2'd2, 1'b1, 1'b1, 8'd5,   1'b0, 1'b0, 16'd88,   8'd0},
    '{1'b1, 7'd0,   3'b101, 7'd0, 3'b001, 2'd1, 1'b0, 1'b1, 8'd2,   1'b0, 1'b0, 16'd44,   8'd0},
    '{1'b0, 7'd2,   3'b011, 7'd0, 3'b000, 2'd1, 1'b1, 1'b0, 8'd1,   1'b0, 1'b0, 16'd60,   8'd2},
    '{1'b0, 7'd127, 3'b000, 7'd0, 3'b000, 2'd0, 1'b0, 1'b0, 8'd128, 1'b0, 1'b0, 16'd1024, 8'd0},
    '{1'b0, 7'd1,   3'b000, 7'd0, 3'b000, 2'd1, 1'b0, 1'b0, 8'd2,   1'b1, 1'b0, 16'd16,   8'd0},
    '{1'b1, 7'd1,   3'b001, 7'd1, 3'b000, 2'd1, 1'b0, 1'b0, 8'd4,   1'b0, 1'b1, 16'd40,   8'd0}
  };

  logic        clk, rst_n, bclk, fs_in;
  logic        cfg_dual, cfg_clk_pol, cfg_fs_pol;
  logic [6:0]  cfg_cnt1, cfg_cnt2;
  logic [2:0]  cfg_wd1, cfg_wd2;
  logic [1:0]  cfg_dly;
  logic        in_valid, in_ready, dx, dx_oe, underflow;
  logic [31:0] in_data;

  logic [31:0] words [0:255];
  logic        exp_a [0:4095];
  int          feed_idx, feed_n, uf_seen;
  logic        feed_en, feed_clr, uf_clr;
  int          checks, errors;

  frame_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs_in(fs_in),
    .cfg_dual(cfg_dual), .cfg_cnt1(cfg_cnt1), .cfg_wd1(cfg_wd1),
    .cfg_cnt2(cfg_cnt2), .cfg_wd2(cfg_wd2), .cfg_dly(cfg_dly),
    .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dx(dx), .dx_oe(dx_oe), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign in_valid = feed_en && (feed_idx < feed_n);
  assign in_data  = words[feed_idx[7:0]];

  // word supply and underflow counting, synchronous to the design
  always @(posedge clk) begin
    if (feed_clr)                  feed_idx <= 0;
    else if (in_valid && in_ready) feed_idx <= feed_idx + 1;
    if (uf_clr)         uf_seen <= 0;
    else if (underflow) uf_seen <= uf_seen + 1;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'b000:  return 8;
      3'b001:  return 12;
      3'b010:  return 16;
      3'b011:  return 20;
      3'b100:  return 24;
      default: return 32;
    endcase
  endfunction

  function automatic string vec_tag(input int vi);
    case (vi)
      0: return "R2 R3 R4 8-bit dly1";
      1: return "R4 R5 16-bit phase2 ignored";
      2: return "R6 R3 R2 inverted clk and fs, dly2";
      3: return "R6 R4 32 then 12 bits";
      4: return "R9 repeated word";
      5: return "R6 128 elements";
      6: return "R10 same-cycle word";
      default: return "R11 fs during frame";
    endcase
  endfunction

  task automatic run_vec(input int vi);
    vec_t v;
    logic act_lvl, idle_b, drv_lvl;
    int   total, dly, ncyc, oe_cnt, eg;
    v       = VECS[vi];
    act_lvl = ~v.fsp;
    idle_b  = v.clkp;
    drv_lvl = ~v.clkp;
    dly     = (v.dly == 2'd3) ? 2 : int'(v.dly);
    @(negedge clk);
    cfg_dual = v.dual; cfg_cnt1 = v.c1; cfg_wd1 = v.w1;
    cfg_cnt2 = v.c2;   cfg_wd2 = v.w2;  cfg_dly = v.dly;
    cfg_clk_pol = v.clkp; cfg_fs_pol = v.fsp;
    fs_in = ~act_lvl;
    feed_clr = 1'b1; uf_clr = 1'b1; feed_en = 1'b0; feed_n = int'(v.nw);
    total = 0; eg = 0;
    for (int ph = 0; ph < (v.dual ? 2 : 1); ph++) begin
      int n, w;
      n = ((ph == 0) ? int'(v.c1) : int'(v.c2)) + 1;
      w = wbits((ph == 0) ? v.w1 : v.w2);
      for (int e = 0; e < n; e++) begin
        logic [31:0] wd;
        wd = (eg < int'(v.nw)) ? words[eg] : words[int'(v.nw) - 1];
        for (int b = w - 1; b >= 0; b--) begin
          exp_a[total] = wd[b];
          total++;
        end
        eg++;
      end
    end
    @(negedge clk);
    feed_clr = 1'b0; uf_clr = 1'b0; feed_en = !v.late;
    repeat (5) @(negedge clk);
    bclk = idle_b;
    repeat (10) @(negedge clk);
    ncyc = total + dly + 3;
    oe_cnt = 0;
    for (int k = 0; k < ncyc; k++) begin
      int j;
      bclk  = drv_lvl;
      fs_in = ((k == 0) || (v.refs && k == dly + 1 + total / 2)) ? act_lvl : ~act_lvl;
      j = k - 1 - dly;
      for (int t = 1; t <= HB; t++) begin
        @(negedge clk);
        if (v.late && k == dly + 1 && t == 2) feed_en = 1'b1;
        if (t == 3) begin
          logic eoe, edx;
          eoe = (j >= 0) && (j < total);
          edx = eoe ? exp_a[j] : 1'b0;
          if (dx_oe) oe_cnt++;
          check(dx_oe === eoe, "R7 output enable", {31'd0, dx_oe}, {31'd0, eoe});
          check(dx === edx, vec_tag(vi), {31'd0, dx}, {31'd0, edx});
        end
      end
      bclk = idle_b;
      repeat (HB) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(oe_cnt == int'(v.exp_bits), "R7 driven bit count", oe_cnt, 32'(v.exp_bits));
    check(uf_seen == int'(v.exp_uf), "R9 R10 underflow pulses", uf_seen, 32'(v.exp_uf));
    check(feed_idx == int'(v.nw), "R8 words consumed", feed_idx, 32'(v.nw));
    feed_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < 256; i++)
      words[i] = (32'h9E37_79B9 * (i + 1)) ^ 32'hC3A5_5A3C;
    rst_n = 1'b0; bclk = 1'b0; fs_in = 1'b0;
    cfg_dual = 1'b0; cfg_cnt1 = '0; cfg_wd1 = '0; cfg_cnt2 = '0; cfg_wd2 = '0;
    cfg_dly = '0; cfg_clk_pol = 1'b0; cfg_fs_pol = 1'b0;
    feed_en = 1'b0; feed_clr = 1'b1; uf_clr = 1'b1; feed_n = 0;
    repeat (5) @(negedge clk);
    // R1: state while reset is held
    check(dx_oe === 1'b0 && dx === 1'b0, "R1 line idle in reset", {30'd0, dx_oe, dx}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    feed_clr = 1'b0; uf_clr = 1'b0;
    check(dx_oe === 1'b0, "R1 dx_oe after reset", {31'd0, dx_oe}, 32'd0);
    check(in_ready === 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    check(underflow === 1'b0, "R1 underflow after reset", {31'd0, underflow}, 32'd0);

    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // R11: a second edge inside the frame did not start a new frame
    repeat (4 * HB) @(negedge clk);
    check(dx_oe === 1'b0 && dx === 1'b0, "R11 R7 idle after last frame",
          {30'd0, dx_oe, dx}, 32'd0);
    check(in_ready === 1'b1, "R8 buffer empty at end", {31'd0, in_ready}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule